// File: doc/BRIEF.md
# Dual-Issue Dispatch Hazard Unit

This block is the purely combinational control core of a two-wide, in-order, five-stage integer pipeline. It looks at the pair of instructions in decode, at both slots of the three stages behind them (ID/EX, EX/MEM, MEM/WB) and at the branch outcome from execute. From these it decides four things. It decides whether the pair may advance. It decides whether the younger decode slot has to be dropped so that it comes back as the older slot of the next fetch group. It decides how far the program counter moves. It also decides where each source operand of the pair in execute gets its value.

No data flows through the unit: every pin is a plain control or status level, and all outputs follow the inputs within the same cycle. The surrounding pipeline applies the results at its next clock edge. Decode fields arrive already decoded as register numbers and class flags. The load, store and control-flow flags mean the instruction is of that class. A write flag means the instruction updates its destination register.

Top module: `dual_issue_hazard`

## Requirements
- R1: When the older decode slot is a load whose write flag is set and whose destination is not register 0, and either source of the younger decode slot equals that destination, `squash_y` is 1 and `pc_step` is 1 (+4).
- R2: When the older decode slot is a branch or jump, `squash_y` is 1 and `pc_step` is 1 (+4).
- R3: When the older decode slot is a store and the younger decode slot is a load, `squash_y` is 1. A store followed by a non-load gives no squash and `pc_step` 0 (+8).
- R4: When any source of a dispatching decode slot equals the non-zero destination of a load in either ID/EX slot, `stall` is 1, `squash_y` is 0 and `pc_step` is 3 (hold).
- R5: `pc_step` is encoded as 0 for +8 (both slots go), 1 for +4 (only the older slot goes), 2 for the branch target and 3 for hold.
- R6: `br_taken` forces `flush` to 1, `pc_step` to 2, and both `stall` and `squash_y` to 0, whatever the other inputs are.
- R7: Each execute-stage operand of the younger slot gets a 3-bit source code. The codes are 0 for the register file, 1 for MEM/WB older, 2 for MEM/WB younger, 3 for EX/MEM older, 4 for EX/MEM younger and 5 for the same-cycle result of the older execute slot.
- R8: Each execute-stage operand of the older slot gets a 2-bit stage code and a lane bit. The stage code is 0 for the register file, 1 for MEM/WB and 2 for EX/MEM. The lane bit is 1 when the younger slot of that stage is the source.
- R9: Among matching producers, the youngest wins. The order is same-cycle older execute slot, EX/MEM younger, EX/MEM older, MEM/WB younger, MEM/WB older, register file. Within one stage the younger slot beats the older one.
- R10: No operand is forwarded when its register number is 0, from a producer whose write flag is clear, or from an EX/MEM slot that holds a load.
- R11: A younger decode slot that is squashed does not cause a stall. If it is squashed and its source matches an ID/EX load destination, `stall` stays 0 and `pc_step` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d0_rs1 | input | REG_W | Older decode slot, first source register |
| d0_rs2 | input | REG_W | Older decode slot, second source register |
| d0_rd | input | REG_W | Older decode slot, destination register |
| d0_wr | input | 1 | Older decode slot writes its destination |
| d0_load | input | 1 | Older decode slot is a load |
| d0_store | input | 1 | Older decode slot is a store |
| d0_ctrl | input | 1 | Older decode slot is a branch or jump |
| d1_rs1 | input | REG_W | Younger decode slot, first source register |
| d1_rs2 | input | REG_W | Younger decode slot, second source register |
| d1_load | input | 1 | Younger decode slot is a load |
| e0_rs1 | input | REG_W | Older execute slot, first source |
| e0_rs2 | input | REG_W | Older execute slot, second source |
| e0_rd | input | REG_W | Older execute slot, destination |
| e0_wr | input | 1 | Older execute slot writes |
| e0_load | input | 1 | Older execute slot is a load |
| e1_rs1 | input | REG_W | Younger execute slot, first source |
| e1_rs2 | input | REG_W | Younger execute slot, second source |
| e1_rd | input | REG_W | Younger execute slot, destination |
| e1_wr | input | 1 | Younger execute slot writes |
| e1_load | input | 1 | Younger execute slot is a load |
| m0_rd | input | REG_W | Older EX/MEM slot, destination |
| m0_wr | input | 1 | Older EX/MEM slot writes |
| m0_load | input | 1 | Older EX/MEM slot is a load |
| m1_rd | input | REG_W | Younger EX/MEM slot, destination |
| m1_wr | input | 1 | Younger EX/MEM slot writes |
| m1_load | input | 1 | Younger EX/MEM slot is a load |
| w0_rd | input | REG_W | Older MEM/WB slot, destination |
| w0_wr | input | 1 | Older MEM/WB slot writes |
| w1_rd | input | REG_W | Younger MEM/WB slot, destination |
| w1_wr | input | 1 | Younger MEM/WB slot writes |
| br_taken | input | 1 | Branch in execute resolved taken |
| stall | output | 1 | Hold both decode slots this cycle |
| squash_y | output | 1 | Drop the younger decode slot |
| flush | output | 1 | Kill the younger decode and execute entries |
| pc_step | output | 2 | Next-PC choice (R5 encoding) |
| fa_o_stage | output | 2 | Older execute slot, first operand stage code |
| fa_o_lane | output | 1 | Older execute slot, first operand lane |
| fb_o_stage | output | 2 | Older execute slot, second operand stage code |
| fb_o_lane | output | 1 | Older execute slot, second operand lane |
| fa_y | output | 3 | Younger execute slot, first operand source code |
| fb_y | output | 3 | Younger execute slot, second operand source code |

## Verification
The bench targets conflicts between two rules. One case is a branch that is taken while a load-use stall is also pending; a design that let the stall win would freeze a wrong-path pair instead of redirecting. Another case is a squashed younger slot that also matches a load in execute; a design that counted it would stall for no reason and lose a cycle. For forwarding, the bench places the same register in several producers at once. It expects the youngest to be chosen, including the same-cycle older result over EX/MEM, and a younger slot over an older one within a stage. A wrong priority would hand the consumer stale data. The bench also checks register 0, clear write flags and loads in EX/MEM. A design that forwarded from any of these would feed garbage into the ALU.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Next-PC choice
  typedef enum logic [1:0] {
    PC_PLUS8  = 2'd0,
    PC_PLUS4  = 2'd1,
    PC_TARGET = 2'd2,
    PC_HOLD   = 2'd3
  } pc_step_e;

  // Full source codes (younger execute slot uses all of them)
  localparam logic [2:0] SRC_RF   = 3'd0;
  localparam logic [2:0] SRC_WB0  = 3'd1;
  localparam logic [2:0] SRC_WB1  = 3'd2;
  localparam logic [2:0] SRC_MEM0 = 3'd3;
  localparam logic [2:0] SRC_MEM1 = 3'd4;
  localparam logic [2:0] SRC_EX0  = 3'd5;

  // Stage codes for the older execute slot
  localparam logic [1:0] STG_RF  = 2'd0;
  localparam logic [1:0] STG_WB  = 2'd1;
  localparam logic [1:0] STG_MEM = 2'd2;

endpackage

// File: rtl/hz_pair_rules.sv
module hz_pair_rules #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] old_rd,
  input  logic             old_wr,
  input  logic             old_load,
  input  logic             old_store,
  input  logic             old_ctrl,
  input  logic [REG_W-1:0] yng_rs1,
  input  logic [REG_W-1:0] yng_rs2,
  input  logic             yng_load,
  output logic             drop_yng
);
  logic load_dep, mem_order;

  always_comb begin
    load_dep  = old_load && old_wr && (old_rd != '0) &&
                ((yng_rs1 == old_rd) || (yng_rs2 == old_rd));
    mem_order = old_store && yng_load;
    drop_yng  = load_dep || old_ctrl || mem_order;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0][REG_W-1:0] srcs,
  input  logic [REG_W-1:0]            ld0_rd,
  input  logic                        ld0,
  input  logic [REG_W-1:0]            ld1_rd,
  input  logic                        ld1,
  output logic                        hit
);
  logic [N_SRC-1:0] per_src;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign per_src[i] = (srcs[i] != '0) &&
                        ((ld0 && (srcs[i] == ld0_rd)) ||
                         (ld1 && (srcs[i] == ld1_rd)));
  end

  assign hit = |per_src;
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter bit SAME_CYCLE = 1'b0
) (
  input  logic [REG_W-1:0] rs,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] m0_rd,
  input  logic             m0_ok,
  input  logic [REG_W-1:0] m1_rd,
  input  logic             m1_ok,
  input  logic [REG_W-1:0] w0_rd,
  input  logic             w0_wr,
  input  logic [REG_W-1:0] w1_rd,
  input  logic             w1_wr,
  output logic [2:0]       code
);
  logic ex_hit;

  if (SAME_CYCLE) begin : g_same
    assign ex_hit = ex_wr && !ex_load && (ex_rd == rs);
  end else begin : g_none
    logic unused_ex;
    assign unused_ex = ^{ex_rd, ex_wr, ex_load};
    assign ex_hit    = 1'b0;
  end

  always_comb begin
    code = SRC_RF;
    if (rs != '0) begin
      if (ex_hit)                          code = SRC_EX0;
      else if (m1_ok && (m1_rd == rs))     code = SRC_MEM1;
      else if (m0_ok && (m0_rd == rs))     code = SRC_MEM0;
      else if (w1_wr && (w1_rd == rs))     code = SRC_WB1;
      else if (w0_wr && (w0_rd == rs))     code = SRC_WB0;
    end
  end
endmodule

// File: rtl/dual_issue_hazard.sv
module dual_issue_hazard
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] d0_rs1,
  input  logic [REG_W-1:0] d0_rs2,
  input  logic [REG_W-1:0] d0_rd,
  input  logic             d0_wr,
  input  logic             d0_load,
  input  logic             d0_store,
  input  logic             d0_ctrl,
  input  logic [REG_W-1:0] d1_rs1,
  input  logic [REG_W-1:0] d1_rs2,
  input  logic             d1_load,
  input  logic [REG_W-1:0] e0_rs1,
  input  logic [REG_W-1:0] e0_rs2,
  input  logic [REG_W-1:0] e0_rd,
  input  logic             e0_wr,
  input  logic             e0_load,
  input  logic [REG_W-1:0] e1_rs1,
  input  logic [REG_W-1:0] e1_rs2,
  input  logic [REG_W-1:0] e1_rd,
  input  logic             e1_wr,
  input  logic             e1_load,
  input  logic [REG_W-1:0] m0_rd,
  input  logic             m0_wr,
  input  logic             m0_load,
  input  logic [REG_W-1:0] m1_rd,
  input  logic             m1_wr,
  input  logic             m1_load,
  input  logic [REG_W-1:0] w0_rd,
  input  logic             w0_wr,
  input  logic [REG_W-1:0] w1_rd,
  input  logic             w1_wr,
  input  logic             br_taken,
  output logic             stall,
  output logic             squash_y,
  output logic             flush,
  output logic [1:0]       pc_step,
  output logic [1:0]       fa_o_stage,
  output logic             fa_o_lane,
  output logic [1:0]       fb_o_stage,
  output logic             fb_o_lane,
  output logic [2:0]       fa_y,
  output logic [2:0]       fb_y
);
  localparam int N_OPS = 2;

  logic drop_raw, hz_old, hz_yng;
  logic e0_ld_live, e1_ld_live, m0_ok, m1_ok;

  assign e0_ld_live = e0_load && e0_wr;
  assign e1_ld_live = e1_load && e1_wr;
  assign m0_ok      = m0_wr && !m0_load;
  assign m1_ok      = m1_wr && !m1_load;

  // ---------------- inter-slot rules ----------------
  hz_pair_rules #(.REG_W(REG_W)) u_pair (
    .old_rd   (d0_rd),
    .old_wr   (d0_wr),
    .old_load (d0_load),
    .old_store(d0_store),
    .old_ctrl (d0_ctrl),
    .yng_rs1  (d1_rs1),
    .yng_rs2  (d1_rs2),
    .yng_load (d1_load),
    .drop_yng (drop_raw)
  );

  // ---------------- load-use against ID/EX ----------------
  hz_load_use #(.REG_W(REG_W), .N_SRC(N_OPS)) u_lu_old (
    .srcs  ({d0_rs2, d0_rs1}),
    .ld0_rd(e0_rd), .ld0(e0_ld_live),
    .ld1_rd(e1_rd), .ld1(e1_ld_live),
    .hit   (hz_old)
  );

  hz_load_use #(.REG_W(REG_W), .N_SRC(N_OPS)) u_lu_yng (
    .srcs  ({d1_rs2, d1_rs1}),
    .ld0_rd(e0_rd), .ld0(e0_ld_live),
    .ld1_rd(e1_rd), .ld1(e1_ld_live),
    .hit   (hz_yng)
  );

  // ---------------- dispatch decision ----------------
  always_comb begin
    flush    = br_taken;
    stall    = !br_taken && (hz_old || (hz_yng && !drop_raw));
    squash_y = !br_taken && !stall && drop_raw;
    if (br_taken)      pc_step = PC_TARGET;
    else if (stall)    pc_step = PC_HOLD;
    else if (drop_raw) pc_step = PC_PLUS4;
    else               pc_step = PC_PLUS8;
  end

  // ---------------- forwarding selects ----------------
  logic [N_OPS-1:0][REG_W-1:0] old_src, yng_src;
  logic [N_OPS-1:0][2:0]       old_code, yng_code;
  logic [N_OPS-1:0][1:0]       old_stage;
  logic [N_OPS-1:0]            old_lane;

  assign old_src = {e0_rs2, e0_rs1};
  assign yng_src = {e1_rs2, e1_rs1};

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    hz_fwd_pick #(.REG_W(REG_W), .SAME_CYCLE(1'b0)) u_old (
      .rs(old_src[k]),
      .ex_rd(e0_rd), .ex_wr(e0_wr), .ex_load(e0_load),
      .m0_rd(m0_rd), .m0_ok(m0_ok), .m1_rd(m1_rd), .m1_ok(m1_ok),
      .w0_rd(w0_rd), .w0_wr(w0_wr), .w1_rd(w1_rd), .w1_wr(w1_wr),
      .code(old_code[k])
    );

    hz_fwd_pick #(.REG_W(REG_W), .SAME_CYCLE(1'b1)) u_yng (
      .rs(yng_src[k]),
      .ex_rd(e0_rd), .ex_wr(e0_wr), .ex_load(e0_load),
      .m0_rd(m0_rd), .m0_ok(m0_ok), .m1_rd(m1_rd), .m1_ok(m1_ok),
      .w0_rd(w0_rd), .w0_wr(w0_wr), .w1_rd(w1_rd), .w1_wr(w1_wr),
      .code(yng_code[k])
    );

    always_comb begin
      unique case (old_code[k])
        SRC_WB0:  begin old_stage[k] = STG_WB;  old_lane[k] = 1'b0; end
        SRC_WB1:  begin old_stage[k] = STG_WB;  old_lane[k] = 1'b1; end
        SRC_MEM0: begin old_stage[k] = STG_MEM; old_lane[k] = 1'b0; end
        SRC_MEM1: begin old_stage[k] = STG_MEM; old_lane[k] = 1'b1; end
        default:  begin old_stage[k] = STG_RF;  old_lane[k] = 1'b0; end
      endcase
    end
  end

  assign fa_o_stage = old_stage[0];
  assign fa_o_lane  = old_lane[0];
  assign fb_o_stage = old_stage[1];
  assign fb_o_lane  = old_lane[1];
  assign fa_y       = yng_code[0];
  assign fb_y       = yng_code[1];

endmodule

// File: rtl/hz_checker.sv
module hz_checker
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             d0_ctrl,
  input logic [REG_W-1:0] e0_rd,
  input logic             e0_wr,
  input logic [REG_W-1:0] e1_rs1,
  input logic [REG_W-1:0] m1_rd,
  input logic             m1_wr,
  input logic             m1_load,
  input logic             br_taken,
  input logic             stall,
  input logic             squash_y,
  input logic             flush,
  input logic [1:0]       pc_step,
  input logic [1:0]       fa_o_stage,
  input logic             fa_o_lane,
  input logic [2:0]       fa_y
);
  always_comb begin
    if (!$isunknown({d0_ctrl, br_taken, stall, squash_y, flush, pc_step})) begin
      // R6
      flush_wins_chk: assert (!(flush && (stall || squash_y)) &&
                              (flush == br_taken) &&
                              (!flush || pc_step == PC_TARGET));
      // R4
      hold_means_stall_chk: assert ((pc_step == PC_HOLD) == stall);
      // R2
      ctrl_drops_yng_chk: assert (!(d0_ctrl && !br_taken && !stall) || squash_y);
      // R5
      plus4_on_squash_chk: assert (!squash_y || pc_step == PC_PLUS4);
    end
    if (!$isunknown({fa_y, e1_rs1, e0_rd, e0_wr, m1_rd, m1_wr, m1_load})) begin
      // R10
      no_zero_fwd_chk: assert (e1_rs1 != '0 || fa_y == SRC_RF);
      // R7
      same_cycle_src_chk: assert (fa_y != SRC_EX0 || (e0_wr && e0_rd == e1_rs1));
      // R10
      mem1_legal_chk: assert (fa_y != SRC_MEM1 ||
                              (m1_wr && !m1_load && m1_rd == e1_rs1));
      // R7
      code_range_chk: assert (fa_y <= SRC_EX0);
    end
    if (!$isunknown({fa_o_stage, fa_o_lane})) begin
      // R8
      lane_needs_stage_chk: assert (!fa_o_lane || fa_o_stage != STG_RF);
    end
  end
endmodule

bind dual_issue_hazard hz_checker #(.REG_W(REG_W)) u_hz_chk (
  .d0_ctrl   (d0_ctrl),
  .e0_rd     (e0_rd),
  .e0_wr     (e0_wr),
  .e1_rs1    (e1_rs1),
  .m1_rd     (m1_rd),
  .m1_wr     (m1_wr),
  .m1_load   (m1_load),
  .br_taken  (br_taken),
  .stall     (stall),
  .squash_y  (squash_y),
  .flush     (flush),
  .pc_step   (pc_step),
  .fa_o_stage(fa_o_stage),
  .fa_o_lane (fa_o_lane),
  .fa_y      (fa_y)
);

// File: tb/test_dual_issue_hazard.sv
module test_dual_issue_hazard;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [RW-1:0] d0_rs1, d0_rs2, d0_rd, d1_rs1, d1_rs2;
  logic d0_wr, d0_load, d0_store, d0_ctrl, d1_load;
  logic [RW-1:0] e0_rs1, e0_rs2, e0_rd, e1_rs1, e1_rs2, e1_rd;
  logic e0_wr, e0_load, e1_wr, e1_load;
  logic [RW-1:0] m0_rd, m1_rd, w0_rd, w1_rd;
  logic m0_wr, m0_load, m1_wr, m1_load, w0_wr, w1_wr, br_taken;
  logic stall, squash_y, flush, fa_o_lane, fb_o_lane;
  logic [1:0] pc_step, fa_o_stage, fb_o_stage;
  logic [2:0] fa_y, fb_y;

  int checks = 0;
  int failures = 0;

  dual_issue_hazard #(.REG_W(RW)) i_dual_issue_hazard (
    .d0_rs1, .d0_rs2, .d0_rd, .d0_wr, .d0_load, .d0_store, .d0_ctrl,
    .d1_rs1, .d1_rs2, .d1_load,
    .e0_rs1, .e0_rs2, .e0_rd, .e0_wr, .e0_load,
    .e1_rs1, .e1_rs2, .e1_rd, .e1_wr, .e1_load,
    .m0_rd, .m0_wr, .m0_load, .m1_rd, .m1_wr, .m1_load,
    .w0_rd, .w0_wr, .w1_rd, .w1_wr, .br_taken,
    .stall, .squash_y, .flush, .pc_step,
    .fa_o_stage, .fa_o_lane, .fb_o_stage, .fb_o_lane, .fa_y, .fb_y
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    {d0_rs1, d0_rs2, d0_rd, d1_rs1, d1_rs2} = '0;
    {d0_wr, d0_load, d0_store, d0_ctrl, d1_load} = '0;
    {e0_rs1, e0_rs2, e0_rd, e1_rs1, e1_rs2, e1_rd} = '0;
    {e0_wr, e0_load, e1_wr, e1_load} = '0;
    {m0_rd, m1_rd, w0_rd, w1_rd} = '0;
    {m0_wr, m0_load, m1_wr, m1_load, w0_wr, w1_wr, br_taken} = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_idle();
    idle(); settle();
    chk("R5", "idle stall", stall, 0);
    chk("R5", "idle squash", squash_y, 0);
    chk("R6", "idle flush", flush, 0);
    chk("R5", "idle pc +8", pc_step, 0);
    chk("R7", "idle fa_y", fa_y, 0);
    chk("R8", "idle fa stage", fa_o_stage, 0);
  endtask

  task automatic t_load_dep();
    idle(); d0_load = 1; d0_wr = 1; d0_rd = 5; d1_rs2 = 5; settle();
    chk("R1", "load dep squash", squash_y, 1);
    chk("R1", "load dep pc +4", pc_step, 1);
    d0_rd = 0; d1_rs2 = 0; settle();
    chk("R1", "x0 load dest no squash", squash_y, 0);
    chk("R1", "x0 load dest pc +8", pc_step, 0);
  endtask

  task automatic t_ctrl();
    idle(); d0_ctrl = 1; d1_rs1 = 3; settle();
    chk("R2", "ctrl squash", squash_y, 1);
    chk("R2", "ctrl pc +4", pc_step, 1);
  endtask

  task automatic t_store_load();
    idle(); d0_store = 1; d1_load = 1; settle();
    chk("R3", "store-load squash", squash_y, 1);
    d1_load = 0; settle();
    chk("R3", "store-alu no squash", squash_y, 0);
    chk("R3", "store-alu pc +8", pc_step, 0);
  endtask

  task automatic t_load_use();
    idle(); e1_load = 1; e1_wr = 1; e1_rd = 7; d0_rs1 = 7; settle();
    chk("R4", "load-use stall", stall, 1);
    chk("R4", "load-use pc hold", pc_step, 3);
    chk("R4", "load-use no squash", squash_y, 0);
    idle(); e0_load = 1; e0_wr = 1; e0_rd = 9; d1_rs2 = 9; settle();
    chk("R4", "younger load-use stall", stall, 1);
  endtask

  task automatic t_squashed_no_stall();
    idle(); d0_ctrl = 1; d1_rs1 = 7; e0_load = 1; e0_wr = 1; e0_rd = 7; settle();
    chk("R11", "squashed yng no stall", stall, 0);
    chk("R11", "squashed yng squash", squash_y, 1);
    chk("R11", "squashed yng pc +4", pc_step, 1);
  endtask

  task automatic t_flush();
    idle(); e1_load = 1; e1_wr = 1; e1_rd = 7; d0_rs1 = 7; d0_ctrl = 1;
    br_taken = 1; settle();
    chk("R6", "flush set", flush, 1);
    chk("R6", "flush no stall", stall, 0);
    chk("R6", "flush no squash", squash_y, 0);
    chk("R6", "flush pc target", pc_step, 2);
  endtask

  task automatic t_fwd_young();
    idle(); e1_rs1 = 9; e0_rd = 9; e0_wr = 1; m1_rd = 9; m1_wr = 1; settle();
    chk("R9", "same-cycle beats EX/MEM", fa_y, 5);
    e0_wr = 0; settle();
    chk("R7", "EX/MEM younger code", fa_y, 4);
    idle(); e1_rs2 = 3; w0_rd = 3; w0_wr = 1; settle();
    chk("R7", "MEM/WB older code", fb_y, 1);
    w1_rd = 3; w1_wr = 1; settle();
    chk("R9", "MEM/WB younger beats older", fb_y, 2);
    m0_rd = 3; m0_wr = 1; settle();
    chk("R9", "EX/MEM older beats MEM/WB", fb_y, 3);
  endtask

  task automatic t_fwd_old();
    idle(); e0_rs1 = 4; m0_rd = 4; m0_wr = 1; e0_rd = 4; e0_wr = 1; settle();
    chk("R8", "older EX/MEM stage", fa_o_stage, 2);
    chk("R8", "older EX/MEM lane 0", fa_o_lane, 0);
    m1_rd = 4; m1_wr = 1; settle();
    chk("R9", "older picks EX/MEM younger lane", fa_o_lane, 1);
    idle(); e0_rs2 = 6; w1_rd = 6; w1_wr = 1; settle();
    chk("R8", "older MEM/WB stage", fb_o_stage, 1);
    chk("R8", "older MEM/WB lane 1", fb_o_lane, 1);
  endtask

  task automatic t_fwd_block();
    idle(); e1_rs1 = 0; e0_rd = 0; e0_wr = 1; m0_rd = 0; m0_wr = 1; settle();
    chk("R10", "x0 not forwarded", fa_y, 0);
    idle(); e1_rs1 = 4; m0_rd = 4; m0_wr = 0; settle();
    chk("R10", "no write flag no fwd", fa_y, 0);
    m1_rd = 4; m1_wr = 1; m1_load = 1; w0_rd = 4; w0_wr = 1; settle();
    chk("R10", "EX/MEM load skipped", fa_y, 1);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    t_idle();
    t_load_dep();
    t_ctrl();
    t_store_load();
    t_load_use();
    t_squashed_no_stall();
    t_flush();
    t_fwd_young();
    t_fwd_old();
    t_fwd_block();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule